// File: doc/BRIEF.md
# Serial Byte Receiver with Idle-Line Event

This block receives asynchronous serial frames of eight data bits, no parity bit and one stop bit. It oversamples the incoming line and delivers each byte on a parallel output. The byte comes with a single-cycle strobe, so a downstream consumer such as a DMA engine can store it directly. Each delivered byte also carries a flag that says whether its stop bit was valid.

A burst of unknown length often ends without reaching any fill threshold of the consumer. To cover that case, the block watches the line once a byte has arrived. If the line then stays high for one full character time, about ten bit times, the block raises a one-cycle idle event and sets a level flag. A new frame during that countdown cancels it, so a burst produces exactly one event, at its end.

The bit rate comes from a runtime divisor input that is captured while the receiver is disabled. A tick occurs every `baud_div_i` clock cycles, and sixteen ticks make one bit time.

Top module: `uart_idle_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, then a high stop bit. Each received byte appears on `data_o` while `valid_o` is high for exactly one clock cycle.
- R2: The line is sampled on an oversampling tick every `baud_div_i` clocks, with 16 ticks per bit. Each bit is decided by a majority of the samples at ticks 7, 8 and 9, counted from the tick that saw the start edge. A disturbance affecting one of the three samples does not change the byte.
- R3: When the majority of the start-bit samples is high, the event is a false start. No byte is delivered and the receiver returns to waiting.
- R4: A low majority in the stop bit still delivers the byte, with `frame_err_o` = 1 during its `valid_o` cycle. A high stop bit gives `frame_err_o` = 0.
- R5: After a byte, if the line stays high, `idle_evt_o` pulses for one cycle. The pulse comes 160 ticks after the `valid_o` cycle, which is exactly 160 × `baud_div_i` clocks when the divisor is at least 2.
- R6: The idle countdown starts only when a byte is delivered. A line that has carried no byte since enable produces no idle event, and one quiet period yields only one event.
- R7: A low sample during the countdown cancels it. No event is produced for a gap shorter than a character time between two frames.
- R8: `idle_flag_o` goes high together with the idle event. It is cleared when the next start bit is detected and while `en_i` is low.
- R9: `baud_div_i` is captured while `en_i` is low and held while enabled. Changing it while enabled has no effect on reception.
- R10: While `en_i` is low, no byte and no idle event are produced. After reset `valid_o`, `idle_evt_o` and `idle_flag_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low loads the divisor |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| baud_div_i | input | DIV_W | Clocks per oversampling tick |
| data_o | output | DATA_W | Last received byte |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| frame_err_o | output | 1 | Stop bit of the current byte was low |
| idle_evt_o | output | 1 | One-cycle idle-line event |
| idle_flag_o | output | 1 | Line idle since last burst |

## Verification
The bench uses the default parameters: 8 data bits, 16 ticks per bit, a 10-bit idle window and a two-stage synchronizer. It sets the divisor to 4 and later to 6, so one character takes 640 or 960 clocks. At these rates dozens of frames, gaps and idle countdowns fit in a short run, and the exact idle latency of 160 × divisor clocks can be checked to the cycle. At a divisor of 4, a disturbance three clocks long is shorter than one tick, so it can reach only one of the three vote samples.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;
  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q, lim;

  assign lim    = (div_q == '0) ? '0 : div_q - 1'b1;
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      div_q <= div_i;   // capture only while disabled
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(div_q));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_idle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_s_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              start_o
);
  localparam int SC_W   = $clog2(OVS);
  localparam int BC_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int VOTE_A = OVS / 2 - 1;
  localparam int VOTE_B = OVS / 2;
  localparam int VOTE_C = OVS / 2 + 1;

  rx_state_e         state_q;
  logic [SC_W-1:0]   sc_q;
  logic [BC_W-1:0]   bc_q;
  logic [1:0]        vote_q;
  logic [DATA_W-1:0] shreg_q, data_q;
  logic              ferr_q, valid_q, start_q;
  logic              bit_maj;

  assign bit_maj = (vote_q[1] & vote_q[0]) | (vote_q[1] & rx_s_i) | (vote_q[0] & rx_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_WAIT;
      sc_q    <= '0;
      bc_q    <= '0;
      vote_q  <= '1;
      shreg_q <= '0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
      valid_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      start_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_WAIT;
        sc_q    <= '0;
      end else if (tick_i) begin
        if (state_q == RX_WAIT) begin
          if (!rx_s_i) begin
            state_q <= RX_START;
            sc_q    <= SC_W'(1);
            start_q <= 1'b1;
          end
        end else begin
          sc_q <= (sc_q == SC_W'(OVS - 1)) ? '0 : sc_q + 1'b1;
          if (sc_q == SC_W'(VOTE_A)) vote_q[0] <= rx_s_i;
          if (sc_q == SC_W'(VOTE_B)) vote_q[1] <= rx_s_i;
          if (sc_q == SC_W'(VOTE_C)) begin
            unique case (state_q)
              RX_START: if (bit_maj) state_q <= RX_WAIT;   // false start
              RX_DATA:  shreg_q <= {bit_maj, shreg_q[DATA_W-1:1]};
              RX_STOP: begin
                data_q  <= shreg_q;
                ferr_q  <= !bit_maj;
                valid_q <= 1'b1;
                state_q <= RX_WAIT;  // release at mid stop bit
              end
              default: ;
            endcase
          end
          if (sc_q == SC_W'(OVS - 1)) begin
            if (state_q == RX_START) begin
              state_q <= RX_DATA;
              bc_q    <= '0;
            end else if (state_q == RX_DATA) begin
              if (bc_q == BC_W'(DATA_W - 1)) state_q <= RX_STOP;
              else                           bc_q    <= bc_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
  assign start_o = start_q;

  // R1
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R10
  valid_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(en_i));
  // R3
  start_leaves_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> $past(!rx_s_i));
endmodule

// File: rtl/uart_idle_det.sv
module uart_idle_det #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic rx_s_i,
  input  logic byte_i,
  input  logic start_i,
  output logic evt_o,
  output logic flag_o
);
  localparam int IDLE_TICKS = OVS * IDLE_BITS;
  localparam int CNT_W      = $clog2(IDLE_TICKS + 1);

  logic             armed_q, evt_q, flag_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      evt_q <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
        flag_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (start_i) flag_q <= 1'b0;
        if (byte_i) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end else if (armed_q && tick_i) begin
          if (!rx_s_i) begin
            armed_q <= 1'b0;   // new activity cancels countdown
            cnt_q   <= '0;
          end else if (cnt_q == CNT_W'(IDLE_TICKS - 1)) begin
            evt_q   <= 1'b1;
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign evt_o  = evt_q;
  assign flag_o = flag_q;

  // R5
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  // R5
  evt_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(rx_s_i));
  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && en_i) |-> flag_q);
  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !flag_q);
  // R10
  evt_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !evt_q);
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int OVS         = 16,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              idle_evt_o,
  output logic              idle_flag_o
);
  logic rx_s, tick, start;

  uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  uart_os_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(baud_div_i), .tick_o(tick)
  );

  uart_frame_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .rx_s_i(rx_s),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(frame_err_o), .start_o(start)
  );

  uart_idle_det #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .rx_s_i(rx_s),
    .byte_i(valid_o), .start_i(start), .evt_o(idle_evt_o), .flag_o(idle_flag_o)
  );
endmodule

// File: tb/sim_uart_idle_rx.sv
module sim_uart_idle_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int IDLE_BITS  = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        rx_i = 1'b1;
  logic [15:0] baud_div_i = 16'd4;
  logic [7:0]  data_o;
  logic        valid_o, frame_err_o, idle_evt_o, idle_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int vcnt = 0;
  int icnt = 0;
  int last_valid = 0;
  int last_idle = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_idle_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .rx_i(rx_i), .baud_div_i(baud_div_i),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
    .idle_evt_o(idle_evt_o), .idle_flag_o(idle_flag_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as bytes come out
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      vcnt++;
      last_valid = cyc;
      if (exp_q.size() == 0) chk(1'b0, "R1/R10 unexpected byte", int'({frame_err_o, data_o}), 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({frame_err_o, data_o} == e, "R1/R2/R4 byte", int'({frame_err_o, data_o}), int'(e));
      end
    end
    if (rst_ni && idle_evt_o) begin
      icnt++;
      last_idle = cyc;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: glitch_bit >= 0 inverts that data bit for glen clocks near its middle
  task automatic send(input logic [7:0] b, input logic stop_lvl, input int div,
                      input bit expect_it, input int glitch_bit, input int glen);
    int bitclk;
    bitclk = div * OVS;
    if (expect_it) exp_q.push_back({~stop_lvl, b});
    rx_i = 1'b0;
    wait_clk(bitclk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      if (i == glitch_bit) begin
        wait_clk(bitclk / 2);
        rx_i = ~b[i];
        wait_clk(glen);
        rx_i = b[i];
        wait_clk(bitclk - bitclk / 2 - glen);
      end else wait_clk(bitclk);
    end
    rx_i = stop_lvl;
    wait_clk(bitclk);
    rx_i = 1'b1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int i0;
    wait_clk(5);
    // R10 reset state
    chk(valid_o == 1'b0 && idle_evt_o == 1'b0 && idle_flag_o == 1'b0, "R10 reset outputs",
        int'({valid_o, idle_evt_o, idle_flag_o}), 0);
    rst_ni = 1'b1;
    wait_clk(5);
    baud_div_i = 16'd4;
    wait_clk(2);
    en_i = 1'b1;

    // R6 quiet line after enable: no idle event
    wait_clk(3 * 640);
    chk(icnt == 0, "R6 no idle without traffic", icnt, 0);

    // R3 short low pulse is a false start
    rx_i = 1'b0; wait_clk(3); rx_i = 1'b1;
    wait_clk(1000);
    chk(vcnt == 0, "R3 false start no byte", vcnt, 0);

    // R1 back-to-back burst
    send(8'h55, 1'b1, 4, 1'b1, -1, 0);
    send(8'h00, 1'b1, 4, 1'b1, -1, 0);
    send(8'hFF, 1'b1, 4, 1'b1, -1, 0);
    send(8'hA3, 1'b1, 4, 1'b1, -1, 0);
    wait_clk(1500);
    chk(vcnt == 4, "R1 burst byte count", vcnt, 4);
    chk(icnt == 1, "R6 one idle per burst", icnt, 1);
    chk(last_idle - last_valid == 160 * 4, "R5 idle latency div4", last_idle - last_valid, 640);
    chk(idle_flag_o == 1'b1, "R8 flag set by idle", int'(idle_flag_o), 1);

    // R2 single-sample disturbances; R8 flag cleared by start
    send(8'h3C, 1'b1, 4, 1'b1, 0, 3);
    chk(idle_flag_o == 1'b0, "R8 flag cleared on start", int'(idle_flag_o), 0);
    send(8'hC3, 1'b1, 4, 1'b1, 2, 3);
    wait_clk(1500);
    chk(icnt == 2, "R2 idle after glitched pair", icnt, 2);

    // R7 gap shorter than a character cancels the countdown
    i0 = icnt;
    send(8'h12, 1'b1, 4, 1'b1, -1, 0);
    wait_clk(300);
    send(8'h34, 1'b1, 4, 1'b1, -1, 0);
    wait_clk(1500);
    chk(icnt == i0 + 1, "R7 single idle after short gap", icnt, i0 + 1);
    chk(last_idle - last_valid == 640, "R7 idle measured from last byte", last_idle - last_valid, 640);

    // R4 framing error still delivers, next good byte clean
    send(8'h81, 1'b0, 4, 1'b1, -1, 0);
    wait_clk(200);
    send(8'h42, 1'b1, 4, 1'b1, -1, 0);
    wait_clk(1500);

    // R9 divisor change while enabled has no effect
    baud_div_i = 16'd7;
    wait_clk(20);
    send(8'h9E, 1'b1, 4, 1'b1, -1, 0);
    wait_clk(1500);

    // R8/R10 disable clears flag
    en_i = 1'b0;
    wait_clk(3);
    chk(idle_flag_o == 1'b0, "R8 flag cleared while disabled", int'(idle_flag_o), 0);

    // R10 no reception while disabled
    i0 = vcnt;
    send(8'h77, 1'b1, 4, 1'b0, -1, 0);
    wait_clk(1500);
    chk(vcnt == i0 && icnt == 5, "R10 disabled no output", vcnt, i0);

    // R9 new divisor captured while disabled
    baud_div_i = 16'd6;
    wait_clk(3);
    en_i = 1'b1;
    wait_clk(50);
    send(8'h6B, 1'b1, 6, 1'b1, -1, 0);
    wait_clk(2000);
    chk(last_idle - last_valid == 160 * 6, "R9 idle latency div6", last_idle - last_valid, 960);
    chk(exp_q.size() == 0, "R1 all expected bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule